// File: doc/BRIEF.md
# Per-Warp Register Hazard Scoreboard

This block keeps, for every warp of a multithreaded in-order core, the set of architectural registers that still have a write in flight. The issue stage asks it whether a candidate instruction may go ahead. When an instruction issues, its destination registers are marked pending. When its results have been written back, they are cleared again. A combinational query port takes a warp and the instruction's destination and source register numbers. It answers with a single hazard bit that the issue logic uses as a stall condition.

Each instruction names up to four destination registers, and register number zero stands for "no register". The query covers both the sources and the destinations, so read-after-write and write-after-write dependences both stall. Write-after-read is not tracked, because operands are read in issue order. Releasing a register that is not pending is harmless. Reserving one that is already pending is a protocol violation: it is reported on a sticky error output, and the whole offending reservation is discarded.

Top module: `warp_hazard_scoreboard`

## Requirements
- R1: A synchronous active-high reset clears the pending set of every warp and the error output; after reset no query reports a hazard.
- R2: Reservations and releases addressed to one warp never change the pending set of any other warp.
- R3: A reservation marks every register number in its four slots that is non-zero; slot k occupies bits [k*REG_W +: REG_W] of the slot bus, slot values of zero are skipped, and a number repeated across slots of one reservation counts once without error.
- R4: A release clears the named non-zero registers of its warp; releasing a register that is not pending changes nothing and raises no error.
- R5: If any register of a reservation is still pending (after a same-cycle release is taken into account), the error output goes high on the next clock and no slot of that reservation is applied.
- R6: The query reports a hazard when any non-zero source register number is pending for the queried warp.
- R7: The query reports a hazard when any non-zero destination register number is pending for the queried warp; zero fields in the query never cause a hazard.
- R8: The query is combinational and reflects the pending set before the updates applied at the coming clock edge.
- R9: When the same warp and register are released and reserved in one cycle, the release is applied first, so the register ends pending and no error is raised.
- R10: Once set, the error output stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rsv_valid | input | 1 | Reservation request this cycle |
| rsv_warp | input | WARP_W | Warp of the reservation |
| rsv_regs | input | SLOTS*REG_W | Destination register numbers to reserve, slot 0 in the low bits |
| rel_valid | input | 1 | Release request this cycle |
| rel_warp | input | WARP_W | Warp of the release |
| rel_regs | input | SLOTS*REG_W | Destination register numbers to release |
| chk_warp | input | WARP_W | Warp of the hazard query |
| chk_dst | input | SLOTS*REG_W | Destination register numbers of the queried instruction |
| chk_src | input | SLOTS*REG_W | Source register numbers of the queried instruction |
| chk_hazard | output | 1 | High when a queried register is pending |
| err_sticky | output | 1 | Sticky flag for a reservation of a pending register |

## Verification
The bench goes after the ordering cases. A query made in the same cycle as a reservation must still see the old state. A design that forwarded the update would stall one cycle too early. A same-cycle release and reserve of one register must leave it pending with no error. A design that applied the reserve before the release would either drop the register or raise a false error. A colliding reservation must be discarded in full: a design that applied its non-colliding slots would later report a hazard on a register that was never granted. The bench also checks that releases of unreserved registers, zero register fields and traffic to a neighbouring warp leave the queried warp's hazard result unchanged.

// File: rtl/whs_pkg.sv
package whs_pkg;

   // Index width that is never zero, so that single-entry configurations still elaborate.
   function automatic int idx_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/whs_slot_decode.sv
// Turns a bus of register-number slots into a register bit mask.
// Slot value zero means "no register" and never sets a bit.
module whs_slot_decode #(
   parameter int NUM_REGS = 64,
   parameter int SLOTS    = 4,
   localparam int REG_W   = whs_pkg::idx_width(NUM_REGS)
) (
   input  logic                   en_i,
   input  logic [SLOTS*REG_W-1:0] slots_i,
   output logic [NUM_REGS-1:0]    mask_o
);

   localparam logic [NUM_REGS-1:0] ONE = {{(NUM_REGS-1){1'b0}}, 1'b1};
   localparam logic [REG_W:0]      LIMIT = (REG_W+1)'(NUM_REGS);

   logic [NUM_REGS-1:0] onehot [SLOTS];

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      logic [REG_W-1:0] num;
      assign num = slots_i[k*REG_W +: REG_W];
      assign onehot[k] = (en_i && (num != '0) && ({1'b0, num} < LIMIT))
                         ? (ONE << num) : '0;
   end

   always_comb begin
      mask_o = '0;
      for (int k = 0; k < SLOTS; k++) begin
         mask_o = mask_o | onehot[k];
      end
   end

endmodule

// File: rtl/whs_warp_row.sv
// Pending-write bit vector for one warp. Clears are applied before sets.
module whs_warp_row #(
   parameter int NUM_REGS = 64
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_REGS-1:0] clr_mask_i,
   input  logic [NUM_REGS-1:0] set_mask_i,
   output logic [NUM_REGS-1:0] pend_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_o <= '0;
      end else begin
         pend_o <= (pend_o & ~clr_mask_i) | set_mask_i;
      end
   end

endmodule

// File: rtl/warp_hazard_scoreboard.sv
module warp_hazard_scoreboard #(
   parameter int NUM_WARPS = 8,
   parameter int NUM_REGS  = 64,
   parameter int SLOTS     = 4,
   localparam int WARP_W   = whs_pkg::idx_width(NUM_WARPS),
   localparam int REG_W    = whs_pkg::idx_width(NUM_REGS)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   rsv_valid,
   input  logic [WARP_W-1:0]      rsv_warp,
   input  logic [SLOTS*REG_W-1:0] rsv_regs,
   input  logic                   rel_valid,
   input  logic [WARP_W-1:0]      rel_warp,
   input  logic [SLOTS*REG_W-1:0] rel_regs,
   input  logic [WARP_W-1:0]      chk_warp,
   input  logic [SLOTS*REG_W-1:0] chk_dst,
   input  logic [SLOTS*REG_W-1:0] chk_src,
   output logic                   chk_hazard,
   output logic                   err_sticky
);

   localparam logic [WARP_W:0] WARP_LIMIT = (WARP_W+1)'(NUM_WARPS);

   // Elaboration-time parameter checks
   if (NUM_WARPS < 1) begin : g_bad_warps
      $error("warp_hazard_scoreboard: NUM_WARPS must be at least 1");
   end
   if (NUM_REGS < 2) begin : g_bad_regs
      $error("warp_hazard_scoreboard: NUM_REGS must be at least 2");
   end
   if (SLOTS < 1) begin : g_bad_slots
      $error("warp_hazard_scoreboard: SLOTS must be at least 1");
   end

   logic [NUM_REGS-1:0] rsv_mask, rel_mask, cdst_mask, csrc_mask;

   whs_slot_decode #(.NUM_REGS(NUM_REGS), .SLOTS(SLOTS)) u_dec_rsv (
      .en_i(rsv_valid), .slots_i(rsv_regs), .mask_o(rsv_mask));
   whs_slot_decode #(.NUM_REGS(NUM_REGS), .SLOTS(SLOTS)) u_dec_rel (
      .en_i(rel_valid), .slots_i(rel_regs), .mask_o(rel_mask));
   whs_slot_decode #(.NUM_REGS(NUM_REGS), .SLOTS(SLOTS)) u_dec_cdst (
      .en_i(1'b1), .slots_i(chk_dst), .mask_o(cdst_mask));
   whs_slot_decode #(.NUM_REGS(NUM_REGS), .SLOTS(SLOTS)) u_dec_csrc (
      .en_i(1'b1), .slots_i(chk_src), .mask_o(csrc_mask));

   logic [NUM_REGS-1:0]           pend [NUM_WARPS];
   logic [NUM_WARPS*NUM_REGS-1:0] pend_flat;

   // Collision test for the reservation against the post-release state
   logic                rsv_in_range, rel_in_range, chk_in_range;
   logic [NUM_REGS-1:0] rsv_target, rsv_after_rel;
   logic                rsv_conflict;

   assign rsv_in_range = ({1'b0, rsv_warp} < WARP_LIMIT);
   assign rel_in_range = ({1'b0, rel_warp} < WARP_LIMIT);
   assign chk_in_range = ({1'b0, chk_warp} < WARP_LIMIT);

   assign rsv_target    = rsv_in_range ? pend[rsv_warp] : '0;
   assign rsv_after_rel = rsv_target &
                          ~((rel_valid && rel_in_range && (rel_warp == rsv_warp)) ? rel_mask : '0);
   assign rsv_conflict  = rsv_valid && rsv_in_range && (|(rsv_after_rel & rsv_mask));

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic [NUM_REGS-1:0] clr_w, set_w;
      assign clr_w = (rel_valid && (rel_warp == WARP_W'(w))) ? rel_mask : '0;
      assign set_w = (rsv_valid && !rsv_conflict && (rsv_warp == WARP_W'(w))) ? rsv_mask : '0;

      whs_warp_row #(.NUM_REGS(NUM_REGS)) u_row (
         .clk       (clk),
         .rst       (rst),
         .clr_mask_i(clr_w),
         .set_mask_i(set_w),
         .pend_o    (pend[w])
      );

      assign pend_flat[w*NUM_REGS +: NUM_REGS] = pend[w];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         err_sticky <= 1'b0;
      end else if (rsv_conflict) begin
         err_sticky <= 1'b1;
      end
   end

   logic [NUM_REGS-1:0] chk_row;
   assign chk_row    = chk_in_range ? pend[chk_warp] : '0;
   assign chk_hazard = |(chk_row & (cdst_mask | csrc_mask));

endmodule

// File: rtl/whs_checker.sv
module whs_checker #(
   parameter int NUM_WARPS = 8,
   parameter int NUM_REGS  = 64,
   localparam int WARP_W   = whs_pkg::idx_width(NUM_WARPS)
) (
   input logic                          clk,
   input logic                          rst,
   input logic                          rsv_valid,
   input logic [WARP_W-1:0]             rsv_warp,
   input logic                          rel_valid,
   input logic [WARP_W-1:0]             rel_warp,
   input logic                          err_sticky,
   input logic [NUM_WARPS*NUM_REGS-1:0] pend_flat
);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!err_sticky && (pend_flat == '0)));

   // R10
   err_hold_chk: assert property (@(posedge clk) disable iff (rst)
      err_sticky |=> err_sticky);

   // R5
   err_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(err_sticky) |-> $past(rsv_valid));

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
      // R2
      warp_isolation_chk: assert property (@(posedge clk) disable iff (rst)
         (!(rsv_valid && rsv_warp == WARP_W'(w)) && !(rel_valid && rel_warp == WARP_W'(w)))
         |=> $stable(pend_flat[w*NUM_REGS +: NUM_REGS]));

      // R4
      release_no_set_chk: assert property (@(posedge clk) disable iff (rst)
         (rel_valid && rel_warp == WARP_W'(w) && !(rsv_valid && rsv_warp == WARP_W'(w)))
         |=> ((pend_flat[w*NUM_REGS +: NUM_REGS] & ~$past(pend_flat[w*NUM_REGS +: NUM_REGS])) == '0));
   end

endmodule

bind warp_hazard_scoreboard whs_checker #(
   .NUM_WARPS(NUM_WARPS),
   .NUM_REGS (NUM_REGS)
) u_whs_checker (
   .clk       (clk),
   .rst       (rst),
   .rsv_valid (rsv_valid),
   .rsv_warp  (rsv_warp),
   .rel_valid (rel_valid),
   .rel_warp  (rel_warp),
   .err_sticky(err_sticky),
   .pend_flat (pend_flat)
);

// File: tb/warp_hazard_scoreboard_tb.sv
module warp_hazard_scoreboard_tb;

   localparam int NW = 8;
   localparam int NR = 64;
   localparam int S  = 4;
   localparam int WW = 3;
   localparam int RW = 6;
   localparam int BW = S*RW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          rsv_valid = 1'b0, rel_valid = 1'b0;
   logic [WW-1:0] rsv_warp = '0, rel_warp = '0, chk_warp = '0;
   logic [BW-1:0] rsv_regs = '0, rel_regs = '0, chk_dst = '0, chk_src = '0;
   logic          chk_hazard, err_sticky;

   always #5 clk = ~clk;

   warp_hazard_scoreboard u_dut (
      .clk(clk), .rst(rst),
      .rsv_valid(rsv_valid), .rsv_warp(rsv_warp), .rsv_regs(rsv_regs),
      .rel_valid(rel_valid), .rel_warp(rel_warp), .rel_regs(rel_regs),
      .chk_warp(chk_warp), .chk_dst(chk_dst), .chk_src(chk_src),
      .chk_hazard(chk_hazard), .err_sticky(err_sticky)
   );

   typedef struct {
      bit    hz;
      bit    err;
      string tag;
   } exp_t;

   exp_t   exp_q[$];
   event   item_ev;
   int     checks = 0;
   int     errors = 0;
   bit     done_flag = 0;

   // Reference model built from the requirements
   logic [NR-1:0] m_pend [NW];
   bit            m_err;

   function automatic logic [BW-1:0] p4(input int a, input int b, input int c, input int d);
      return {RW'(d), RW'(c), RW'(b), RW'(a)};
   endfunction

   function automatic logic [NR-1:0] to_mask(input logic [BW-1:0] f);
      logic [NR-1:0] m = '0;
      for (int k = 0; k < S; k++) begin
         if (f[k*RW +: RW] != '0) m[f[k*RW +: RW]] = 1'b1;
      end
      return m;
   endfunction

   task automatic model_clear();
      for (int w = 0; w < NW; w++) m_pend[w] = '0;
      m_err = 1'b0;
   endtask

   task automatic summary();
      if (!done_flag) begin
         done_flag = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
      end
   endtask

   // Driver: apply one cycle of stimulus, push the expected query result, update the model
   task automatic step(input bit rv, input int rw, input logic [BW-1:0] rr,
                       input bit lv, input int lw, input logic [BW-1:0] lr,
                       input int cw, input logic [BW-1:0] cd, input logic [BW-1:0] cs,
                       input string tag);
      exp_t e;
      logic [NR-1:0] rm;
      @(negedge clk);
      rsv_valid = rv; rsv_warp = WW'(rw); rsv_regs = rr;
      rel_valid = lv; rel_warp = WW'(lw); rel_regs = lr;
      chk_warp  = WW'(cw); chk_dst = cd; chk_src = cs;
      #2;
      e.hz  = |(m_pend[cw] & (to_mask(cd) | to_mask(cs)));
      e.err = m_err;
      e.tag = tag;
      exp_q.push_back(e);
      -> item_ev;
      @(posedge clk);
      if (lv) m_pend[lw] = m_pend[lw] & ~to_mask(lr);
      if (rv) begin
         rm = to_mask(rr);
         if (|(m_pend[rw] & rm)) m_err = 1'b1;
         else m_pend[rw] = m_pend[rw] | rm;
      end
   endtask

   task automatic query(input int cw, input logic [BW-1:0] cd, input logic [BW-1:0] cs,
                        input string tag);
      step(0, 0, '0, 0, 0, '0, cw, cd, cs, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; rsv_valid = 1'b0; rel_valid = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_clear();
   endtask

   // Monitor: pop each expectation and compare against the ports
   initial begin
      exp_t e;
      forever begin
         @(item_ev);
         while (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            checks += 2;
            if (chk_hazard !== e.hz) begin
               errors++;
               $display("FAIL %s chk_hazard: actual %b expected %b", e.tag, chk_hazard, e.hz);
            end
            if (err_sticky !== e.err) begin
               errors++;
               $display("FAIL %s err_sticky: actual %b expected %b", e.tag, err_sticky, e.err);
            end
         end
      end
   end

   // Watchdog
   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      model_clear();
      do_reset();

      // R1: nothing pending after reset, all warps
      query(0, p4(1, 2, 3, 63), p4(4, 5, 6, 7), "R1");
      query(7, p4(1, 2, 3, 63), p4(4, 5, 6, 7), "R1");

      // R8: query in the reservation cycle sees the old state
      step(1, 0, p4(5, 9, 0, 0), 0, 0, '0, 0, '0, p4(5, 0, 0, 0), "R8");
      // R6: pending source stalls
      query(0, '0, p4(0, 0, 5, 0), "R6");
      // R2: other warp unaffected
      query(1, p4(9, 0, 0, 0), p4(5, 0, 0, 0), "R2");
      // R7: pending destination stalls, zero fields never do
      query(0, p4(0, 0, 0, 9), '0, "R7");
      query(0, '0, '0, "R7");

      // R3: all four slots reserved, duplicates count once
      step(1, 0, p4(10, 11, 12, 63), 0, 0, '0, 0, '0, p4(63, 0, 0, 0), "R3");
      query(0, '0, p4(10, 0, 0, 0), "R3");
      query(0, '0, p4(63, 0, 0, 0), "R3");
      query(0, p4(12, 0, 0, 0), '0, "R3");
      step(1, 2, p4(8, 8, 0, 0), 0, 0, '0, 2, '0, p4(8, 0, 0, 0), "R3");
      query(2, '0, p4(8, 0, 0, 0), "R3");

      // R4: release clears, release of unreserved register is ignored
      step(0, 0, '0, 1, 0, p4(5, 0, 0, 0), 0, '0, p4(5, 0, 0, 0), "R4");
      query(0, '0, p4(5, 0, 0, 0), "R4");
      step(0, 0, '0, 1, 0, p4(40, 0, 0, 0), 0, '0, p4(40, 0, 0, 0), "R4");
      query(0, '0, p4(9, 0, 0, 0), "R4");
      query(0, '0, p4(40, 0, 0, 0), "R4");

      // R5: colliding reservation raises error and is dropped whole
      step(1, 0, p4(20, 9, 0, 0), 0, 0, '0, 0, '0, p4(20, 0, 0, 0), "R5");
      query(0, '0, p4(20, 0, 0, 0), "R5");
      // R10: error stays high
      query(0, '0, '0, "R10");
      step(0, 0, '0, 1, 0, p4(9, 0, 0, 0), 0, '0, p4(9, 0, 0, 0), "R10");
      query(0, '0, p4(9, 0, 0, 0), "R10");

      // R1: reset clears tables and error
      do_reset();
      query(0, p4(10, 11, 12, 63), '0, "R1");
      query(2, '0, p4(8, 0, 0, 0), "R1");

      // R9: same-cycle release and reserve of one register
      step(1, 3, p4(7, 0, 0, 0), 0, 0, '0, 3, '0, '0, "R9");
      step(1, 3, p4(7, 0, 0, 0), 1, 3, p4(7, 0, 0, 0), 3, '0, p4(7, 0, 0, 0), "R9");
      query(3, '0, p4(7, 0, 0, 0), "R9");

      // R2: release on another warp leaves warp 3 pending
      step(0, 0, '0, 1, 4, p4(7, 0, 0, 0), 3, p4(7, 0, 0, 0), '0, "R2");
      query(3, p4(7, 0, 0, 0), '0, "R2");
      query(4, p4(7, 0, 0, 0), '0, "R2");

      // Idle cycle, then report
      @(negedge clk);
      rsv_valid = 1'b0; rel_valid = 1'b0;
      #2;
      summary();
      $finish;
   end

endmodule